// File: doc/BRIEF.md
# Multiway Predicated Branch Resolver

This block resolves a group of up to four branch operations that leave the decoder together in one wide instruction word. Each slot carries an operation kind (empty, branch when the predicate is true, branch when the predicate is false, or branch always), a one-bit predicate, a flag saying the predicate is Not-a-Result (NaR), and a target address. The slots are ranked by index. The block reduces the group to a single outcome: transfer to one target, fall through, or fault.

Because the ranking is fixed, a compiler can write a compound condition such as `(x && y) || z` as one instruction. Slots are visited in order and evaluation stops at the first decided slot, so short-circuit semantics hold. A NaR predicate only matters if the scan actually reaches it. The outcome is registered and appears on the cycle after the instruction is presented, which is the one cycle of transfer overhead. The fetch side consumes the registered taken flag and target.

Top module: `mwb_resolver`

## Requirements
- R1: While reset is asserted and until the first instruction after reset, `out_valid`, `out_taken`, `out_fault` and `out_target` are all zero.
- R2: Every outcome appears exactly one clock after its instruction: `out_valid` equals the previous cycle's `issue_valid`.
- R3: The operation code sits in bits [2s+1:2s] of `slot_op` for slot s. Code 1 (branch if true) decides its slot with a transfer to that slot's target when its predicate is 1 and not NaR.
- R4: Code 2 (branch if false) decides its slot with a transfer when its predicate is 0 and not NaR.
- R5: Code 3 (branch always) decides its slot with a transfer regardless of the predicate value and the NaR flag of that slot.
- R6: When several slots would transfer, the lowest-indexed deciding slot wins. Its target (bits [ADDR_W*(s+1)-1:ADDR_W*s] of `slot_target`) is loaded into `out_target`.
- R7: A conditional slot (code 1 or 2) reached by the scan with its NaR flag set decides the group as a fault. `out_fault` is raised, `out_taken` stays low and `out_target` keeps its previous value.
- R8: NaR flags and predicates of slots after the deciding slot have no effect on the outcome.
- R9: When no slot decides, the instruction falls through. `out_valid` is high, `out_taken` and `out_fault` are low, and `out_target` keeps its previous value.
- R10: In a cycle with `issue_valid` low, the next cycle shows `out_taken` and `out_fault` low, and `out_target` is unchanged.
- R11: An empty slot (code 0) is skipped whatever its predicate and NaR flag are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| issue_valid | input | 1 | The slot vectors hold a branch group this cycle |
| slot_op | input | 2*NUM_SLOTS | Per-slot operation code: 0 empty, 1 if-true, 2 if-false, 3 always |
| slot_pred | input | NUM_SLOTS | Per-slot predicate value |
| slot_nar | input | NUM_SLOTS | Per-slot flag marking the predicate as Not-a-Result |
| slot_target | input | ADDR_W*NUM_SLOTS | Per-slot branch target |
| out_valid | output | 1 | Registered: an outcome is present |
| out_taken | output | 1 | Registered: transfer to `out_target` |
| out_fault | output | 1 | Registered: a consulted predicate was NaR |
| out_target | output | ADDR_W | Registered next-fetch target, held when no transfer occurs |

## Verification
The bench walks through every combination of operation, predicate and NaR flag across all four slots and compares each outcome with an ordered scan computed in the bench. A design that scanned in the wrong direction would pick a higher slot's target. A design that checked NaR on every slot would fault on groups whose NaR sits behind an earlier decided slot or on an empty slot. A design that let a branch-always slot consult its NaR flag would fault where it should transfer. Targets are unique per slot and per combination, so a design that reloaded the target on fall-through, on a fault or on an idle cycle would show a stale-value mismatch.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

  localparam int unsigned OP_W = 2;

  typedef enum logic [OP_W-1:0] {
    BR_EMPTY  = 2'd0,
    BR_IF_SET = 2'd1,
    BR_IF_CLR = 2'd2,
    BR_ALWAYS = 2'd3
  } br_op_e;

  typedef struct packed {
    logic decide;
    logic fault;
  } slot_verdict_t;

endpackage

// File: rtl/mwb_rst_sync.sv
module mwb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_core_n = sync_q[STAGES-1];

endmodule

// File: rtl/mwb_slot_eval.sv
module mwb_slot_eval
  import mwb_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            pred,
  input  logic            nar,
  output slot_verdict_t   verdict
);

  br_op_e kind;

  always_comb begin
    kind           = br_op_e'(op);
    verdict.decide = 1'b0;
    verdict.fault  = 1'b0;
    unique case (kind)
      BR_EMPTY: begin
        verdict.decide = 1'b0;
      end
      BR_IF_SET: begin
        verdict.decide = nar | pred;
        verdict.fault  = nar;
      end
      BR_IF_CLR: begin
        verdict.decide = nar | ~pred;
        verdict.fault  = nar;
      end
      BR_ALWAYS: begin
        verdict.decide = 1'b1;
      end
      default: begin
        verdict.decide = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/mwb_priority.sv
module mwb_priority
  import mwb_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4
) (
  input  slot_verdict_t [NUM_SLOTS-1:0] verdicts,
  output logic [NUM_SLOTS-1:0]          win_onehot,
  output logic                          any_decide,
  output logic                          win_fault
);

  logic [NUM_SLOTS:0] blocked;

  assign blocked[0] = 1'b0;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chain
    assign win_onehot[s]  = verdicts[s].decide & ~blocked[s];
    assign blocked[s+1]   = blocked[s] | verdicts[s].decide;
  end

  assign any_decide = blocked[NUM_SLOTS];

  always_comb begin
    win_fault = 1'b0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      win_fault = win_fault | (win_onehot[s] & verdicts[s].fault);
    end
  end

endmodule

// File: rtl/mwb_target_sel.sv
module mwb_target_sel #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned ADDR_W    = 32
) (
  input  logic [NUM_SLOTS-1:0]        sel_onehot,
  input  logic [NUM_SLOTS*ADDR_W-1:0] targets,
  output logic [ADDR_W-1:0]           picked
);

  always_comb begin
    picked = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      picked = picked | ({ADDR_W{sel_onehot[s]}} & targets[s*ADDR_W +: ADDR_W]);
    end
  end

endmodule

// File: rtl/mwb_resolver.sv
module mwb_resolver
  import mwb_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned ADDR_W    = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          issue_valid,
  input  logic [NUM_SLOTS*OP_W-1:0]     slot_op,
  input  logic [NUM_SLOTS-1:0]          slot_pred,
  input  logic [NUM_SLOTS-1:0]          slot_nar,
  input  logic [NUM_SLOTS*ADDR_W-1:0]   slot_target,
  output logic                          out_valid,
  output logic                          out_taken,
  output logic                          out_fault,
  output logic [ADDR_W-1:0]             out_target
);

  logic                           rst_core_n;
  slot_verdict_t [NUM_SLOTS-1:0]  verdicts;
  logic [NUM_SLOTS-1:0]           win_onehot;
  logic                           any_decide;
  logic                           win_fault;
  logic [ADDR_W-1:0]              picked;

  logic                           valid_d;
  logic                           taken_d;
  logic                           fault_d;
  logic                           tgt_en;
  logic [ADDR_W-1:0]              tgt_d;

  mwb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    mwb_slot_eval u_eval (
      .op      (slot_op[s*OP_W +: OP_W]),
      .pred    (slot_pred[s]),
      .nar     (slot_nar[s]),
      .verdict (verdicts[s])
    );
  end

  mwb_priority #(.NUM_SLOTS(NUM_SLOTS)) u_prio (
    .verdicts   (verdicts),
    .win_onehot (win_onehot),
    .any_decide (any_decide),
    .win_fault  (win_fault)
  );

  mwb_target_sel #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_sel (
    .sel_onehot (win_onehot),
    .targets    (slot_target),
    .picked     (picked)
  );

  // next-state
  always_comb begin
    valid_d = issue_valid;
    taken_d = issue_valid & any_decide & ~win_fault;
    fault_d = issue_valid & any_decide &  win_fault;
    tgt_en  = taken_d;
    tgt_d   = picked;
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      out_valid <= 1'b0;
      out_taken <= 1'b0;
      out_fault <= 1'b0;
    end else begin
      out_valid <= valid_d;
      out_taken <= taken_d;
      out_fault <= fault_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      out_target <= '0;
    end else if (tgt_en) begin
      out_target <= tgt_d;
    end
  end

endmodule

// File: rtl/mwb_resolver_chk.sv
module mwb_resolver_chk #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned ADDR_W    = 32
) (
  input logic                        clk,
  input logic                        rst_core_n,
  input logic                        issue_valid,
  input logic [NUM_SLOTS*2-1:0]      slot_op,
  input logic [NUM_SLOTS-1:0]        slot_nar,
  input logic [NUM_SLOTS*ADDR_W-1:0] slot_target,
  input logic                        out_valid,
  input logic                        out_taken,
  input logic                        out_fault,
  input logic [ADDR_W-1:0]           out_target
);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    issue_valid |=> out_valid);

  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(out_taken && out_fault));

  p_nar_first_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (issue_valid && (slot_op[1:0] == 2'd1 || slot_op[1:0] == 2'd2) && slot_nar[0])
      |=> (out_fault && !out_taken));

  p_always_first_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (issue_valid && slot_op[1:0] == 2'd3)
      |=> (out_taken && out_target == $past(slot_target[ADDR_W-1:0])));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    !out_taken |-> $stable(out_target));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    !issue_valid |=> (!out_taken && !out_fault && !out_valid));

endmodule

bind mwb_resolver mwb_resolver_chk #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .issue_valid (issue_valid),
  .slot_op     (slot_op),
  .slot_nar    (slot_nar),
  .slot_target (slot_target),
  .out_valid   (out_valid),
  .out_taken   (out_taken),
  .out_fault   (out_fault),
  .out_target  (out_target)
);

// File: tb/mwb_resolver_test.sv
`timescale 1ns/1ps
module mwb_resolver_test;

  localparam int N  = 4;
  localparam int AW = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            issue_valid;
  logic [N*2-1:0]  slot_op;
  logic [N-1:0]    slot_pred;
  logic [N-1:0]    slot_nar;
  logic [N*AW-1:0] slot_target;
  logic            out_valid, out_taken, out_fault;
  logic [AW-1:0]   out_target;

  int checks   = 0;
  int failures = 0;
  logic [AW-1:0] exp_tgt;

  always #4 clk = ~clk;

  mwb_resolver #(.NUM_SLOTS(N), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
    .slot_op(slot_op), .slot_pred(slot_pred), .slot_nar(slot_nar),
    .slot_target(slot_target), .out_valid(out_valid), .out_taken(out_taken),
    .out_fault(out_fault), .out_target(out_target)
  );

  task automatic check(input string req, input logic v, input logic t, input logic f,
                       input logic [AW-1:0] tg);
    checks++;
    if (out_valid !== v || out_taken !== t || out_fault !== f || out_target !== tg) begin
      failures++;
      $display("FAIL %s: got v=%b t=%b f=%b tgt=%h, expected v=%b t=%b f=%b tgt=%h",
               req, out_valid, out_taken, out_fault, out_target, v, t, f, tg);
    end
  endtask

  function automatic logic [AW-1:0] tgt_of(input int s, input int combo);
    return {8'(s + 1), 8'h5A, 16'(combo)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    issue_valid = 1'b0;
    slot_op     = '0;
    slot_pred   = '0;
    slot_nar    = '0;
    slot_target = '0;
    exp_tgt     = '0;
    repeat (3) @(negedge clk);
    check("R1", 1'b0, 1'b0, 1'b0, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", 1'b0, 1'b0, 1'b0, '0);

    // Exhaustive sweep: covers R3, R4, R5, R6, R7, R8, R9, R11 and R2 latency.
    for (int combo = 0; combo < 65536; combo++) begin
      logic e_t, e_f, done, later_nar, early_empty_nar;
      int   win, win_op;
      string tag;
      e_t = 0; e_f = 0; done = 0; later_nar = 0; early_empty_nar = 0;
      win = -1; win_op = 0;
      for (int s = 0; s < N; s++) begin
        int op;
        logic p, nr;
        op = (combo >> (4*s)) & 3;
        p  = 1'((combo >> (4*s + 2)) & 1);
        nr = 1'((combo >> (4*s + 3)) & 1);
        slot_op[2*s +: 2]     = 2'(op);
        slot_pred[s]          = p;
        slot_nar[s]           = nr;
        slot_target[s*AW +: AW] = tgt_of(s, combo);
        if (done) begin
          if (nr) later_nar = 1;
        end else if (op == 0) begin
          if (nr) early_empty_nar = 1;
        end else if (op == 3) begin
          done = 1; e_t = 1; win = s; win_op = 3;
        end else if (nr) begin
          done = 1; e_f = 1; win = s;
        end else if ((op == 1 && p) || (op == 2 && !p)) begin
          done = 1; e_t = 1; win = s; win_op = op;
        end
      end
      issue_valid = 1'b1;
      if (e_t) exp_tgt = tgt_of(win, combo);
      if (e_f)                     tag = "R7";
      else if (!e_t)               tag = "R9";
      else if (later_nar)          tag = "R8";
      else if (early_empty_nar)    tag = "R11";
      else if (win > 0)            tag = "R6";
      else if (win_op == 3)        tag = "R5";
      else if (win_op == 1)        tag = "R3";
      else                         tag = "R4";
      @(negedge clk);
      check(tag, 1'b1, e_t, e_f, exp_tgt);
    end

    // R10: idle cycles after a transfer, with slots still set to transfer.
    slot_op   = 8'hFF;
    slot_target = {N{32'hDEAD_BEEF}};
    issue_valid = 1'b1;
    @(negedge clk);
    exp_tgt = 32'hDEAD_BEEF;
    check("R5", 1'b1, 1'b1, 1'b0, exp_tgt);
    slot_target = {N{32'h1234_5678}};
    issue_valid = 1'b0;
    @(negedge clk);
    check("R10", 1'b0, 1'b0, 1'b0, exp_tgt);
    @(negedge clk);
    check("R10", 1'b0, 1'b0, 1'b0, exp_tgt);

    // R2: outcome lands exactly one cycle after the issue.
    slot_op = 8'h01; slot_pred = 4'h1; slot_nar = '0;
    issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0;
    check("R2", 1'b1, 1'b1, 1'b0, 32'h1234_5678);
    @(negedge clk);
    check("R2", 1'b0, 1'b0, 1'b0, 32'h1234_5678);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule